// File: doc/BRIEF.md
# Trace Buffer Readback Controller

This block gives a host bus read access to a trace RAM whose lines are wider than the host data word. Each RAM line is 20 bits wide and the host sees it through a single 16-bit data register, so every line is handed out as two consecutive words. The controller keeps a line pointer and a word-half bit. It drives the pointer to the RAM as the read address and returns lines oldest first, wrapping at the buffer depth.

Reads are allowed only when all of these hold: the capture logic is not armed, tracing is enabled, the system is not secured, and the buffer has been unlocked. Arming locks the buffer. Only an aligned full-word write to the data register while disarmed unlocks it. That write also rewinds the pointer to the oldest stored line, which is the write pointer after a rollover and line 0 otherwise. A read that is not allowed, or that is a byte or misaligned access, returns zero and leaves the pointer and the word-half bit unchanged.

The controller never writes the RAM and keeps no line count, so a system reset cannot disturb the stored trace or its count. A reset leaves the buffer locked with the pointer at line 0.

Top module: `trace_readout_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0, `ram_addr` is 0 and the buffer is locked, so an aligned word read returns 0.
- R2: An aligned word read while `armed` is 1 returns 0 and leaves `ram_addr` unchanged. Once `armed` has been 1, reads return 0 after disarming until the buffer is unlocked.
- R3: The buffer is unlocked only by a write with `host_wide`=1 and `host_addr0`=0 while `armed` is 0. A byte write (`host_wide`=0) or a misaligned write (`host_addr0`=1) leaves it locked.
- R4: A read while `secured` is 1 or `trace_en` is 0 returns 0 and advances neither the pointer nor the word half.
- R5: A byte read (`host_wide`=0) or a misaligned read (`host_addr0`=1) returns 0 and advances neither the pointer nor the word half.
- R6: Of an allowed pair of reads from one line, the first returns line bits [15:0]. The second returns line bits [19:16] in `rd_data[3:0]` with `rd_data[15:4]` zero. Each value appears on `rd_data` one clock after the read strobe and holds until the next read strobe.
- R7: `ram_addr` stays on the same line after the first word is read. It advances by one after the second word, wrapping from DEPTH-1 to 0.
- R8: An unlocking write sets `ram_addr` to `wr_ptr` when `rollover` is 1 and to 0 when `rollover` is 0, one clock after the write strobe.
- R9: An unlocking write between the two words of a line makes the next allowed read return the first word (bits [15:0]) of the oldest line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_rd | input | 1 | Host read strobe to the data register |
| host_wr | input | 1 | Host write strobe to the data register |
| host_addr0 | input | 1 | Host address bit 0; 0 means word aligned |
| host_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| armed | input | 1 | Capture logic is armed |
| trace_en | input | 1 | Tracing is enabled |
| secured | input | 1 | System is secured |
| wr_ptr | input | AW | Next line the capture logic would write |
| rollover | input | 1 | Capture has wrapped past the buffer end |
| ram_rdata | input | 20 | RAM line at `ram_addr`, read combinationally |
| rd_data | output | 16 | Registered host read data |
| ram_addr | output | AW | RAM read address (line pointer) |

## Verification
Every result of this block is due exactly one clock after its strobe. Read data, the pointer step and the word-half toggle are all captured on the edge that sees the read strobe, and the rewind happens on the edge that sees the unlocking write. The bench drives each strobe on a falling edge, lets one rising edge take it, and compares `rd_data` and `ram_addr` on the following falling edge, before any new stimulus. A bench-side model of the RAM supplies line data computed from the address, so each expected word follows from the pointer value that R7 and R8 predict.

// File: rtl/trace_readout_ctrl.sv
module trace_readout_ctrl #(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 20,
  parameter int WORD_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int HI_W  = LINE_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr0,
  input  logic              host_wide,
  input  logic              armed,
  input  logic              trace_en,
  input  logic              secured,
  input  logic [AW-1:0]     wr_ptr,
  input  logic              rollover,
  input  logic [LINE_W-1:0] ram_rdata,
  output logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     ram_addr
);

  logic          locked;
  logic          hi;
  logic [AW-1:0] ptr;

  wire           aligned = host_wide & ~host_addr0;
  wire           restart = host_wr & aligned & ~armed;
  wire           allowed = ~armed & trace_en & ~secured & ~locked;
  wire           rd_ok   = host_rd & aligned & allowed & ~restart;
  wire [AW-1:0]  oldest  = rollover ? wr_ptr : '0;
  wire           last    = (ptr == AW'(DEPTH - 1));
  wire [AW-1:0]  ptr_nxt = last ? '0 : ptr + 1'b1;

  wire [WORD_W-1:0] word_lo = ram_rdata[WORD_W-1:0];
  wire [WORD_W-1:0] word_hi = {{(WORD_W-HI_W){1'b0}}, ram_rdata[LINE_W-1:WORD_W]};

  assign ram_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      hi      <= 1'b0;
      ptr     <= '0;
      rd_data <= '0;
    end else begin
      if (armed)        locked <= 1'b1;
      else if (restart) locked <= 1'b0;

      if (restart) begin
        ptr <= oldest;
        hi  <= 1'b0;
      end else if (rd_ok) begin
        hi <= ~hi;
        if (hi) ptr <= ptr_nxt;
      end

      if (host_rd) rd_data <= rd_ok ? (hi ? word_hi : word_lo) : '0;
    end
  end

  AST_ARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && armed && !host_wr |=> rd_data == '0 && $stable(ram_addr)); // R2
  AST_BAD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && (!host_wide || host_addr0) |=> rd_data == '0 && $stable(ram_addr)); // R5
  AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && (secured || !trace_en) |=> rd_data == '0 && $stable(ram_addr)); // R4
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && !hi |=> $stable(ram_addr)); // R7
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && hi && last |=> ram_addr == '0); // R7
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ram_addr == ($past(rollover) ? $past(wr_ptr) : '0)); // R8
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && locked && !restart |=> rd_data == '0); // R2

endmodule

// File: tb/sim_trace_readout_ctrl.sv
module sim_trace_readout_ctrl;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 0, host_wr = 0, host_addr0 = 0, host_wide = 1;
  logic armed = 0, trace_en = 0, secured = 0, rollover = 0;
  logic [AW-1:0] wr_ptr = '0;
  logic [19:0] ram_rdata;
  logic [15:0] rd_data;
  logic [AW-1:0] ram_addr;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  function automatic logic [19:0] line_of(input logic [AW-1:0] a);
    return {a ^ 4'h9, 16'hA000 + 16'(a) * 16'h0111};
  endfunction

  assign ram_rdata = line_of(ram_addr);

  trace_readout_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr0(host_addr0), .host_wide(host_wide), .armed(armed),
    .trace_en(trace_en), .secured(secured), .wr_ptr(wr_ptr),
    .rollover(rollover), .ram_rdata(ram_rdata), .rd_data(rd_data),
    .ram_addr(ram_addr));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic wide, input logic a0);
    @(negedge clk);
    host_rd = 1; host_wide = wide; host_addr0 = a0;
    @(negedge clk);
    host_rd = 0; host_wide = 1; host_addr0 = 0;
  endtask

  task automatic wr(input logic wide, input logic a0);
    @(negedge clk);
    host_wr = 1; host_wide = wide; host_addr0 = a0;
    @(negedge clk);
    host_wr = 0; host_wide = 1; host_addr0 = 0;
  endtask

  task automatic t_reset;
    chk(32'(rd_data), 0, "R1 rd_data after reset");
    chk(32'(ram_addr), 0, "R1 ram_addr after reset");
    trace_en = 1;
    rd(1, 0);
    chk(32'(rd_data), 0, "R1 locked read");
    chk(32'(ram_addr), 0, "R1 locked read addr");
  endtask

  task automatic t_unlock;
    wr(1, 0);
    chk(32'(ram_addr), 0, "R8 rewind no rollover");
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(0)) & 32'hFFFF, "R6 low word");
    chk(32'(ram_addr), 0, "R7 hold after low word");
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(0)) >> 16, "R6 high word");
    chk(32'(ram_addr), 1, "R7 advance after high word");
  endtask

  task automatic t_bad_access;
    rd(0, 0);
    chk(32'(rd_data), 0, "R5 byte read data");
    chk(32'(ram_addr), 1, "R5 byte read addr");
    rd(1, 1);
    chk(32'(rd_data), 0, "R5 misaligned read data");
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(1)) & 32'hFFFF, "R5 half unchanged");
  endtask

  task automatic t_secure;
    secured = 1;
    rd(1, 0);
    chk(32'(rd_data), 0, "R4 secured data");
    chk(32'(ram_addr), 1, "R4 secured addr");
    secured = 0; trace_en = 0;
    rd(1, 0);
    chk(32'(rd_data), 0, "R4 trace off data");
    trace_en = 1;
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(1)) >> 16, "R4 half held");
    chk(32'(ram_addr), 2, "R4 advance after resume");
  endtask

  task automatic t_armed;
    armed = 1;
    rd(1, 0);
    chk(32'(rd_data), 0, "R2 armed data");
    chk(32'(ram_addr), 2, "R2 armed addr");
    wr(1, 0);
    armed = 0;
    rd(1, 0);
    chk(32'(rd_data), 0, "R2 locked after disarm");
    wr(0, 0);
    rd(1, 0);
    chk(32'(rd_data), 0, "R3 byte write keeps lock");
    wr(1, 1);
    rd(1, 0);
    chk(32'(rd_data), 0, "R3 misaligned write keeps lock");
    wr(1, 0);
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(0)) & 32'hFFFF, "R3 unlocked read");
  endtask

  task automatic t_rollover;
    rollover = 1; wr_ptr = 4'd5;
    wr(1, 0);
    chk(32'(ram_addr), 5, "R8 rewind to oldest");
    for (int i = 0; i < DEPTH; i++) begin
      logic [AW-1:0] ln;
      ln = AW'((5 + i) % DEPTH);
      rd(1, 0);
      chk(32'(rd_data), 32'(line_of(ln)) & 32'hFFFF, "R6 sweep low");
      rd(1, 0);
      chk(32'(rd_data), 32'(line_of(ln)) >> 16, "R6 sweep high");
      chk(32'(ram_addr), 32'((ln + 1) % DEPTH), "R7 sweep wrap");
    end
  endtask

  task automatic t_midline;
    wr_ptr = 4'd9;
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(5)) & 32'hFFFF, "R9 low before restart");
    wr(1, 0);
    chk(32'(ram_addr), 9, "R9 rewind addr");
    rd(1, 0);
    chk(32'(rd_data), 32'(line_of(9)) & 32'hFFFF, "R9 low after restart");
    rollover = 0;
    wr(1, 0);
    chk(32'(ram_addr), 0, "R8 rewind after rollover clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_unlock;
    t_bad_access;
    t_secure;
    t_armed;
    t_rollover;
    t_midline;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule